// File: doc/BRIEF.md
# Daisy-Chained Converter Readout Controller

This controller collects conversion results from a chain of four-channel serial converters that share one data clock. It watches the converters' active-low data-valid strobe and the conversion-toggle line. When a readout window opens, it runs a gated data clock derived from the system clock. It then shifts in one continuous MSB-first bit stream and cuts the stream into per-channel words. Each word is tagged with the position of its device in the chain and its channel number. The word length and the number of devices set the frame length. Each device gives four words of 20 bits (80 clock periods) in the wide format, or of 16 bits (64 periods) in the narrow format.

Two window policies are selectable. In before-toggle mode the frame starts when the data-valid strobe falls, and it must finish within a programmed number of system cycles. That limit is the integration time minus the guard before the next toggle. In after-toggle mode the frame starts a programmed wait after the conversion line changes level, and it must finish before the strobe falls again. A missed deadline stops the clock at once, drops the unfinished word and raises a sticky overrun flag. A fill bit is driven into the head of the chain. It changes only at rising data-clock edges, so it is steady across the falling edges where the converters sample it.

Top module: `adc_chain_reader`

## Requirements
- R1: During and right after synchronous reset, `dclk`, `word_valid`, `frame_done`, `overrun` and `chain_din` are all 0.
- R2: A completed frame gives exactly `dev*80` (wide) or `dev*64` (narrow) data-clock pulses and `dev*4` words. A single `frame_done` pulse follows the last falling data-clock edge, with `dclk` low.
- R3: Words are assembled MSB first in stream order. Word k carries device tag k/4 and channel tag k%4, with device 0 nearest the controller and channels in the order 0,1,2,3. Narrow words sit in bits 15:0 of `word_data`, with bits 19:16 zero.
- R4: The data clock is low whenever no frame is active. During a frame, each high and each low phase lasts `cfg_div` system cycles, with a value of 0 acting as 1.
- R5: In before-toggle mode (`cfg_after`=0), a high-to-low change of `dvalid_n` first seen at clock edge E0 makes `dclk` rise after edge E0+D, where D is the half period. Changes of `conv` start nothing in this mode.
- R6: In after-toggle mode (`cfg_after`=1), a level change of `conv` first seen at edge E0 makes `dclk` rise after edge E0+`cfg_wait`+1+D. A fall of `dvalid_n` while idle starts nothing in this mode.
- R7: In before-toggle mode, a cycle counter starts at 0 in the first cycle of the frame. If it reaches `cfg_deadline` before the cycle that holds the last falling data-clock edge has passed, the frame aborts. The frame completes only if `cfg_deadline` ≥ 2·D·bits. On abort, `dclk` is low after that edge, `overrun` is set, the unfinished word is dropped and no `frame_done` follows.
- R8: In after-toggle mode, a fall of `dvalid_n` during a frame aborts it at the edge where the fall is seen, with the same effects as in R7.
- R9: `overrun` stays 1 until reset, and later frames still run normally.
- R10: `chain_din` takes the value of `fill_bit` only at edges where `dclk` rises, and holds it at all other times, idle included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_dev_count | input | CNT_W | Devices in the chain (1..MAX_DEV; 0 acts as 1) |
| cfg_wide | input | 1 | 1: 20-bit words, 0: 16-bit words |
| cfg_after | input | 1 | 0: before-toggle mode, 1: after-toggle mode |
| cfg_div | input | DIV_W | Data-clock half period in system cycles |
| cfg_wait | input | WAIT_W | Cycles to wait after a conversion toggle (after-toggle mode) |
| cfg_deadline | input | TMR_W | Frame cycle budget (before-toggle mode) |
| dvalid_n | input | 1 | Data-valid strobe from the chain, active low |
| conv | input | 1 | Conversion-toggle line |
| sdata_in | input | 1 | Serial data from the chain tail |
| fill_bit | input | 1 | Bit to drive into the chain head |
| dclk | output | 1 | Gated data clock |
| chain_din | output | 1 | Serial input to the chain head |
| word_valid | output | 1 | One-cycle pulse per completed word |
| word_data | output | WIDE_BITS | Completed word |
| word_dev | output | IDX_W | Device position of the word |
| word_chan | output | CH_W | Channel of the word (0..3) |
| frame_done | output | 1 | Pulse after a completed frame |
| overrun | output | 1 | Sticky deadline-miss flag |

## Verification
Stimulus changes on falling system-clock edges and results are sampled on the following falling edges. A start strobe applied at one falling edge therefore shows `dclk` high at the (D+1)-th falling edge that follows in before-toggle mode, and at the (`cfg_wait`+D+2)-th in after-toggle mode. The bench counts edges to exactly those values, and it also counts D samples in the first high phase. Each word is visible at the falling edge after the rising data-clock edge that delivered its last bit. An abort shows up with `dclk` low and `overrun` high at the first sample after the edge that saw it. The bench computes the expected pulse count from the deadline using the rising-edge cycle formula D−1+2Dj, and the expected word count from that pulse count.

// File: rtl/adc_chain_pkg.sv
package adc_chain_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WAIT  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TAIL  = 2'd3
   } rd_state_t;
endpackage

// File: rtl/rd_dclk_gen.sv
module rd_dclk_gen #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             dclk,
   output logic             rise,
   output logic             fall
);
   logic [DIV_W-1:0] ph;
   logic             tick;

   // half period ends when ph reaches div-1; div of 0 behaves as 1
   assign tick = run && (({1'b0, ph} + 1'b1) >= {1'b0, div});
   assign rise = tick && !dclk;
   assign fall = tick && dclk;

   always_ff @(posedge clk) begin
      if (rst || !run) begin
         ph   <= '0;
         dclk <= 1'b0;
      end else if (tick) begin
         ph   <= '0;
         dclk <= !dclk;
      end else begin
         ph   <= ph + 1'b1;
      end
   end

   // R4: a stopped generator leaves the data clock low
   assert_idle_low_R4: assert property (@(posedge clk) disable iff (rst)
      !run |=> !dclk);
endmodule

// File: rtl/rd_frame_counter.sv
module rd_frame_counter #(
   parameter int MAX_DEV     = 64,
   parameter int CHANS       = 4,
   parameter int WIDE_BITS   = 20,
   parameter int NARROW_BITS = 16,
   localparam int BIT_W = $clog2(WIDE_BITS),
   localparam int CH_W  = $clog2(CHANS),
   localparam int IDX_W = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             step,
   input  logic             wide,
   input  logic [IDX_W-1:0] dev_last,
   output logic             bit_last,
   output logic [CH_W-1:0]  chan,
   output logic [IDX_W-1:0] dev,
   output logic             frame_last
);
   logic [BIT_W-1:0] bit_idx;
   logic             chan_last;

   assign bit_last   = bit_idx == (wide ? BIT_W'(WIDE_BITS - 1) : BIT_W'(NARROW_BITS - 1));
   assign chan_last  = chan == CH_W'(CHANS - 1);
   assign frame_last = bit_last && chan_last && (dev == dev_last);

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         bit_idx <= '0;
         chan    <= '0;
         dev     <= '0;
      end else if (step) begin
         if (bit_last) begin
            bit_idx <= '0;
            if (chan_last) begin
               chan <= '0;
               dev  <= dev + 1'b1;
            end else begin
               chan <= chan + 1'b1;
            end
         end else begin
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end

   // R3: channels advance one at a time within a device
   assert_chan_order_R3: assert property (@(posedge clk) disable iff (rst)
      (step && !clear && bit_last && !chan_last) |=> (chan == $past(chan) + 1'b1));
endmodule

// File: rtl/rd_word_shifter.sv
module rd_word_shifter #(
   parameter int WIDE_BITS   = 20,
   parameter int NARROW_BITS = 16,
   parameter bit ALIGN_MSB   = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 step,
   input  logic                 sdin,
   input  logic                 wide,
   output logic [WIDE_BITS-1:0] word
);
   logic [WIDE_BITS-1:0] sr;
   logic [WIDE_BITS-1:0] full;
   logic [WIDE_BITS-1:0] narrow;

   assign full = {sr[WIDE_BITS-2:0], sdin};

   generate
      if (ALIGN_MSB) begin : g_msb
         assign narrow = {full[NARROW_BITS-1:0], {(WIDE_BITS - NARROW_BITS){1'b0}}};
      end else begin : g_lsb
         assign narrow = {{(WIDE_BITS - NARROW_BITS){1'b0}}, full[NARROW_BITS-1:0]};
      end
   endgenerate

   assign word = wide ? full : narrow;

   always_ff @(posedge clk) begin
      if (rst)       sr <= '0;
      else if (step) sr <= full;
   end
endmodule

// File: rtl/adc_chain_reader.sv
module adc_chain_reader
   import adc_chain_pkg::*;
#(
   parameter int MAX_DEV     = 64,
   parameter int CHANS       = 4,
   parameter int WIDE_BITS   = 20,
   parameter int NARROW_BITS = 16,
   parameter int DIV_W       = 8,
   parameter int WAIT_W      = 16,
   parameter int TMR_W       = 24,
   parameter bit ALIGN_MSB   = 1'b0,
   localparam int CNT_W = $clog2(MAX_DEV + 1),
   localparam int IDX_W = (MAX_DEV > 1) ? $clog2(MAX_DEV) : 1,
   localparam int CH_W  = $clog2(CHANS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [CNT_W-1:0]     cfg_dev_count,
   input  logic                 cfg_wide,
   input  logic                 cfg_after,
   input  logic [DIV_W-1:0]     cfg_div,
   input  logic [WAIT_W-1:0]    cfg_wait,
   input  logic [TMR_W-1:0]     cfg_deadline,
   input  logic                 dvalid_n,
   input  logic                 conv,
   input  logic                 sdata_in,
   input  logic                 fill_bit,
   output logic                 dclk,
   output logic                 chain_din,
   output logic                 word_valid,
   output logic [WIDE_BITS-1:0] word_data,
   output logic [IDX_W-1:0]     word_dev,
   output logic [CH_W-1:0]      word_chan,
   output logic                 frame_done,
   output logic                 overrun
);
   initial begin
      assert (NARROW_BITS >= 2 && NARROW_BITS < WIDE_BITS) else $error("word widths out of order");
      assert (CHANS >= 2 && (CHANS & (CHANS - 1)) == 0) else $error("CHANS must be a power of two");
      assert (WAIT_W <= TMR_W) else $error("wait counter wider than timer");
      assert (MAX_DEV >= 1) else $error("MAX_DEV must be positive");
   end

   rd_state_t        state;
   logic [TMR_W-1:0] tmr;
   logic             dvalid_q, conv_q;
   logic             lat_wide, lat_after;
   logic [IDX_W-1:0] lat_dev_last, dev_last_cfg;
   logic             dv_fall, conv_tgl, active, abort, run;
   logic             rise, fall, step, emit;
   logic             bit_last, frame_last, cnt_clear;
   logic [CH_W-1:0]  cur_chan;
   logic [IDX_W-1:0] cur_dev;
   logic [WIDE_BITS-1:0] asm_word;

   assign dv_fall   = dvalid_q && !dvalid_n;
   assign conv_tgl  = conv ^ conv_q;
   assign active    = (state == ST_SHIFT) || (state == ST_TAIL);
   assign abort     = active && (lat_after ? dv_fall : (tmr == cfg_deadline));
   assign run       = active && !abort;
   assign step      = rise && (state == ST_SHIFT);
   assign emit      = step && bit_last;
   assign cnt_clear = (state == ST_IDLE) || (state == ST_WAIT);

   always_comb begin
      if (cfg_dev_count == '0)
         dev_last_cfg = '0;
      else if (cfg_dev_count > CNT_W'(MAX_DEV))
         dev_last_cfg = IDX_W'(MAX_DEV - 1);
      else
         dev_last_cfg = IDX_W'(cfg_dev_count - 1'b1);
   end

   rd_dclk_gen #(.DIV_W(DIV_W)) i_dclk_gen (
      .clk (clk), .rst (rst), .run (run), .div (cfg_div),
      .dclk(dclk), .rise(rise), .fall(fall)
   );

   rd_frame_counter #(
      .MAX_DEV(MAX_DEV), .CHANS(CHANS),
      .WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS)
   ) i_frame_counter (
      .clk(clk), .rst(rst), .clear(cnt_clear), .step(step), .wide(lat_wide),
      .dev_last(lat_dev_last), .bit_last(bit_last), .chan(cur_chan),
      .dev(cur_dev), .frame_last(frame_last)
   );

   rd_word_shifter #(
      .WIDE_BITS(WIDE_BITS), .NARROW_BITS(NARROW_BITS), .ALIGN_MSB(ALIGN_MSB)
   ) i_word_shifter (
      .clk(clk), .rst(rst), .step(step), .sdin(sdata_in),
      .wide(lat_wide), .word(asm_word)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state        <= ST_IDLE;
         tmr          <= '0;
         dvalid_q     <= 1'b1;
         conv_q       <= 1'b0;
         lat_wide     <= 1'b0;
         lat_after    <= 1'b0;
         lat_dev_last <= '0;
         overrun      <= 1'b0;
         frame_done   <= 1'b0;
         word_valid   <= 1'b0;
         word_data    <= '0;
         word_dev     <= '0;
         word_chan    <= '0;
         chain_din    <= 1'b0;
      end else begin
         dvalid_q   <= dvalid_n;
         conv_q     <= conv;
         frame_done <= 1'b0;
         word_valid <= emit;
         if (emit) begin
            word_data <= asm_word;
            word_dev  <= cur_dev;
            word_chan <= cur_chan;
         end
         if (rise) chain_din <= fill_bit;
         case (state)
            ST_IDLE: begin
               tmr <= '0;
               if ((!cfg_after && dv_fall) || (cfg_after && conv_tgl)) begin
                  state        <= cfg_after ? ST_WAIT : ST_SHIFT;
                  lat_wide     <= cfg_wide;
                  lat_after    <= cfg_after;
                  lat_dev_last <= dev_last_cfg;
               end
            end
            ST_WAIT: begin
               if (tmr == TMR_W'(cfg_wait)) begin
                  state <= ST_SHIFT;
                  tmr   <= '0;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_SHIFT: begin
               if (abort) begin
                  state   <= ST_IDLE;
                  overrun <= 1'b1;
               end else begin
                  tmr <= tmr + 1'b1;
                  if (emit && frame_last) state <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (abort) begin
                  state   <= ST_IDLE;
                  overrun <= 1'b1;
               end else if (fall) begin
                  state      <= ST_IDLE;
                  frame_done <= 1'b1;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R10: the head input only moves together with a rising data clock
   assert_din_hold_R10: assert property (@(posedge clk) disable iff (rst)
      !$stable(chain_din) |-> $rose(dclk));

   // R9: the overrun flag never clears on its own
   assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      overrun |=> overrun);

   // R7: an abort leaves the clock low and reports no completion
   assert_abort_quiet_R7: assert property (@(posedge clk) disable iff (rst)
      $rose(overrun) |-> (!dclk && !frame_done));

   // R2: completion is reported with the data clock parked low
   assert_done_clk_low_R2: assert property (@(posedge clk) disable iff (rst)
      frame_done |-> !dclk);
endmodule

// File: tb/test_adc_chain_reader.sv
module test_adc_chain_reader;
   localparam int MAXD = 3;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic        rst;
   logic [1:0]  cfg_dev_count;
   logic        cfg_wide, cfg_after;
   logic [7:0]  cfg_div;
   logic [15:0] cfg_wait;
   logic [23:0] cfg_deadline;
   logic        dvalid_n, conv, fill_bit;
   logic        sdata_in;
   logic        dclk, chain_din, word_valid, frame_done, overrun;
   logic [19:0] word_data;
   logic [1:0]  word_dev;
   logic [1:0]  word_chan;

   int n_vec = 0, n_bad = 0;
   int p = 0, seed = 0, exp_k = 0, rise_cnt = 0, done_cnt = 0, cur_dev = 1;
   bit cur_wide = 1'b0;
   bit finished = 1'b0;
   logic [19:0] mon_exp;

   adc_chain_reader #(.MAX_DEV(MAXD)) i_adc_chain_reader (
      .clk(clk), .rst(rst), .cfg_dev_count(cfg_dev_count), .cfg_wide(cfg_wide),
      .cfg_after(cfg_after), .cfg_div(cfg_div), .cfg_wait(cfg_wait),
      .cfg_deadline(cfg_deadline), .dvalid_n(dvalid_n), .conv(conv),
      .sdata_in(sdata_in), .fill_bit(fill_bit), .dclk(dclk), .chain_din(chain_din),
      .word_valid(word_valid), .word_data(word_data), .word_dev(word_dev),
      .word_chan(word_chan), .frame_done(frame_done), .overrun(overrun)
   );

   function automatic logic [19:0] wv(input int dev, input int ch, input bit wide, input int sd);
      int h;
      h = (dev * 7 + ch * 3 + 1) * 40503 + sd * 977;
      h = h ^ (h >>> 7);
      return wide ? 20'(h) : {4'b0, 16'(h)};
   endfunction

   function automatic logic sbit(input int pos, input int nd, input bit wide, input int sd);
      int len, tot, q, k, b;
      logic [19:0] v;
      len = wide ? 20 : 16;
      tot = nd * 4 * len;
      q = pos % tot;
      k = q / len;
      b = q % len;
      v = wv(k / 4, k % 4, wide, sd);
      return v[len - 1 - b];
   endfunction

   // chain model: tail bit follows the stream position, advanced on falling data-clock edges
   assign sdata_in = sbit(p, cur_dev, cur_wide, seed);
   always @(negedge dclk) p = p + 1;
   always @(posedge dclk) rise_cnt = rise_cnt + 1;

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, expv);
      end
   endtask

   // R3: every emitted word compared with the stream model
   always @(negedge clk) begin
      if (!rst && word_valid) begin
         mon_exp = wv(exp_k / 4, exp_k % 4, cur_wide, seed);
         chk(word_data == mon_exp, "R3 word data", int'(word_data), int'(mon_exp));
         chk(int'(word_dev) == exp_k / 4 && int'(word_chan) == exp_k % 4, "R3 word tags",
             int'(word_dev) * 4 + int'(word_chan), exp_k);
         exp_k++;
      end
      if (!rst && frame_done) done_cnt++;
   end

   task automatic prep(input int d, input bit w, input int dv);
      @(negedge clk);
      cfg_dev_count = 2'(d);
      cfg_wide = w;
      cfg_div = 8'(dv);
      cur_dev = d;
      cur_wide = w;
      seed++;
      p = 0;
      exp_k = 0;
      rise_cnt = 0;
      done_cnt = 0;
   endtask

   task automatic lat_meas(output int n);
      n = 0;
      do begin
         @(negedge clk);
         n++;
      end while (!dclk && n < 100000);
   endtask

   task automatic frame_before(input int d, input bit w, input int dv, input int dl);
      int n, h, r, dd, len, bits;
      dd = (dv == 0) ? 1 : dv;
      len = w ? 20 : 16;
      bits = d * 4 * len;
      prep(d, w, dv);
      cfg_after = 1'b0;
      cfg_deadline = 24'(dl);
      dvalid_n = 1'b0;
      lat_meas(n);
      dvalid_n = 1'b1;
      chk(n == dd + 1, "R5 start latency", n, dd + 1);
      h = 0;
      while (dclk && h < 1000) begin
         h++;
         @(negedge clk);
      end
      chk(h == dd, "R4 high phase", h, dd);
      repeat (2 * dd * bits + 10) @(negedge clk);
      r = 0;
      for (int j = 0; j < bits; j++) if (dd - 1 + 2 * dd * j < dl) r++;
      chk(rise_cnt == r, "R2 R7 clock pulses", rise_cnt, r);
      chk(exp_k == r / len, "R2 R7 word count", exp_k, r / len);
      chk(done_cnt == ((dl >= 2 * dd * bits) ? 1 : 0), "R2 R7 frame done", done_cnt,
          (dl >= 2 * dd * bits) ? 1 : 0);
      chk(dclk == 1'b0, "R4 clock idle low", int'(dclk), 0);
      if (dl < 2 * dd * bits) chk(overrun == 1'b1, "R7 overrun", int'(overrun), 1);
   endtask

   task automatic frame_after(input int d, input bit w, input int dv, input int wt, input int ab);
      int n, rc, len;
      len = w ? 20 : 16;
      prep(d, w, dv);
      cfg_after = 1'b1;
      cfg_wait = 16'(wt);
      dvalid_n = 1'b0;
      @(negedge clk);
      dvalid_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!dclk && rise_cnt == 0, "R6 strobe ignored while idle", rise_cnt, 0);
      conv = ~conv;
      lat_meas(n);
      chk(n == wt + dv + 2, "R6 start latency", n, wt + dv + 2);
      if (ab > 0) begin
         repeat (ab) @(negedge clk);
         dvalid_n = 1'b0;
         @(negedge clk);
         dvalid_n = 1'b1;
         chk(dclk == 1'b0 && overrun == 1'b1, "R8 abort on strobe", int'(overrun), 1);
         rc = rise_cnt;
         repeat (4 * dv + 10) @(negedge clk);
         chk(rise_cnt == rc, "R8 clock stopped", rise_cnt, rc);
         chk(exp_k < d * 4 && done_cnt == 0, "R8 frame discarded", exp_k * 10 + done_cnt, 0);
      end else begin
         repeat (2 * dv * d * 4 * len + 10) @(negedge clk);
         chk(rise_cnt == d * 4 * len, "R2 after-mode pulses", rise_cnt, d * 4 * len);
         chk(exp_k == d * 4, "R2 after-mode words", exp_k, d * 4);
         chk(done_cnt == 1, "R2 after-mode done", done_cnt, 1);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got 0 expected 1");
         summary();
         $finish;
      end
   end

   initial begin
      rst = 1'b1;
      cfg_dev_count = 2'd1; cfg_wide = 1'b0; cfg_after = 1'b0; cfg_div = 8'd1;
      cfg_wait = 16'd0; cfg_deadline = 24'hFFFFFF;
      dvalid_n = 1'b1; conv = 1'b0; fill_bit = 1'b0;
      repeat (4) @(negedge clk);
      chk(!dclk && !word_valid && !frame_done && !overrun && !chain_din, "R1 in reset",
          int'({dclk, word_valid, frame_done, overrun, chain_din}), 0);
      rst = 1'b0;
      @(negedge clk);
      chk(!dclk && !word_valid && !frame_done && !overrun && !chain_din, "R1 after reset",
          int'({dclk, word_valid, frame_done, overrun, chain_din}), 0);

      fill_bit = 1'b1;
      repeat (3) @(negedge clk);
      chk(chain_din == 1'b0, "R10 idle hold", int'(chain_din), 0);

      for (int d = 1; d <= MAXD; d++)
         for (int w = 0; w < 2; w++)
            for (int dv = 1; dv <= 2; dv++)
               frame_before(d, bit'(w), dv, 24'hFFFFFF);
      frame_before(1, 1'b0, 0, 24'hFFFFFF);
      chk(overrun == 1'b0, "R7 no overrun with ample budget", int'(overrun), 0);
      chk(chain_din == 1'b1, "R10 loaded at rise", int'(chain_din), 1);
      fill_bit = 1'b0;
      repeat (5) @(negedge clk);
      chk(chain_din == 1'b1, "R10 held while idle", int'(chain_din), 1);

      cfg_after = 1'b0;
      rise_cnt = 0;
      conv = ~conv;
      repeat (20) @(negedge clk);
      chk(!dclk && rise_cnt == 0, "R5 toggle ignored", rise_cnt, 0);

      frame_after(2, 1'b1, 1, 0, 0);
      frame_after(3, 1'b0, 2, 7, 0);
      frame_after(1, 1'b1, 3, 30, 0);
      chk(chain_din == 1'b0, "R10 reloaded", int'(chain_din), 0);
      chk(overrun == 1'b0, "R8 no overrun before abort", int'(overrun), 0);
      frame_after(3, 1'b1, 1, 5, 100);

      frame_before(2, 1'b0, 1, 255);
      frame_before(3, 1'b1, 2, 300);
      frame_before(2, 1'b0, 1, 256);
      chk(overrun == 1'b1, "R9 sticky after clean frame", int'(overrun), 1);

      finished = 1'b1;
      summary();
      $finish;
   end
endmodule